// File: doc/BRIEF.md
# Inband Loop Code Detector

This block watches a T1 receive bit stream for a repeating inband loop code of programmable content and length, as used to request or release a line loopback. The receiver's bit strobe qualifies each bit. A marker flags framing bit positions, and a select input decides whether those positions are skipped or treated as ordinary data. The block does not need to know the pattern's phase beforehand. It compares each accepted bit with the accepted bit one code length earlier and counts every disagreement as a bit error.

Bit strobes are grouped into fixed integration periods of `INTV_BITS` strobes, counted from reset. The default is 74,112, which is 48 ms at the T1 line rate. At the end of each period the detect flag is rewritten. It goes to 1 when the error count for that period stays within the budget of 15 and the most recent code-length window of accepted bits is some rotation of the programmed code. Otherwise it goes to 0. The same block serves for either the activate code or the deactivate code, depending on how it is programmed.

Top module: `loop_code_detector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `loop_det` is 0.
- R2: The code is `code_pat[L-1:0]`, with L = `code_len_m1`+1. Bit L-1 is the first bit on the line, so 00001 is `code_pat`=8'h01 with `code_len_m1`=4. An accepted bit is an error when at least L bits have been accepted since reset and the bit differs from the accepted bit L positions earlier. A period with at most 15 errors whose final window matches the code sets `loop_det` to 1.
- R3: A period with 16 errors ends with `loop_det` at 0.
- R4: A period with exactly 15 errors and a matching window ends with `loop_det` at 1.
- R5: `loop_det` changes only at the clock edge that takes the `INTV_BITS`-th strobe of a period. Periods are counted from reset and include framing-marked strobes. At every other edge the flag holds.
- R6: With `framed_sel`=1, a strobed bit that has `fbit_mark`=1 is neither compared, counted as an error nor placed in the window, but it still counts toward the period length.
- R7: With `framed_sel`=0, `fbit_mark` has no effect, and marked bits are handled as ordinary data.
- R8: If the L most recent accepted bits at the end of a period are not a cyclic rotation of the code, the period ends with `loop_det` at 0, even when it had no errors.
- R9: Code length is programmable from 1 to 8. With 001 programmed (`code_pat`=8'h01, `code_len_m1`=2), a clean 001 stream is detected and a 00001 stream is rejected.
- R10: The error count saturates at 16, so a period with any larger number of errors (for example 32) ends with `loop_det` at 0.
- R11: A cycle with `bit_en`=0 has no effect, whatever `rx_bit` and `fbit_mark` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received line bit |
| bit_en | input | 1 | Strobe marking a valid `rx_bit` |
| fbit_mark | input | 1 | Current bit sits in a framing bit position |
| framed_sel | input | 1 | 1: skip marked bits; 0: treat every bit as data |
| code_pat | input | 8 | Loop code, first line bit at index L-1 |
| code_len_m1 | input | 3 | Code length minus one |
| loop_det | output | 1 | Detect flag, rewritten once per period |

## Verification
The assertions assume that `code_len_m1` and `code_pat` change only at a period boundary. Within one period the window check and the error rule then both refer to a single code. The bench changes the code only together with the first bit of a new period. The assertions also assume that framing marks are meaningful only together with a strobe. The bench therefore drives `fbit_mark` freely during idle cycles, which also shows that those cycles are ignored. Error counts are set exactly by flipping isolated bits at known positions. One flip is placed at the last bit of a period so that its second error carries into the next period, giving an odd total of 15.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int PAT_MAX = 8;
    localparam int LEN_W   = $clog2(PAT_MAX);

    typedef logic [PAT_MAX-1:0] pat_t;
    typedef logic [LEN_W-1:0]   len_t;

    // Outcome of one strobed bit
    typedef struct packed {
        logic take;   // bit enters the comparison
        logic miss;   // bit disagrees with the one a code length back
    } bit_eval_t;

    // Window as it will be after the current cycle
    typedef struct packed {
        pat_t win;    // index 0 is the newest accepted bit
        logic full;   // at least a code length of bits accepted
    } window_t;

    // True when win holds the code rotated by rot positions
    function automatic logic rot_fits(pat_t win, pat_t pat, len_t lm1, int rot);
        logic ok;
        int   idx;
        int   lim;
        ok  = 1'b1;
        lim = int'(lm1);
        for (int i = 0; i < PAT_MAX; i++) begin
            if (i <= lim) begin
                idx = i + rot;
                if (idx > lim) idx = idx - (lim + 1);
                if (win[i] != pat[idx]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/lcd_history.sv
module lcd_history
    import lcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      rx_bit,
    input  logic      skip,
    input  len_t      len_m1,
    output pat_t      hist_q,
    output window_t   win_nx,
    output bit_eval_t eval
);

    localparam int FILL_W = LEN_W + 1;

    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_nx;
    logic              full_now;

    assign full_now = fill_q > {1'b0, len_m1};

    always_comb begin
        eval.take = bit_en & ~skip;
        eval.miss = eval.take & full_now & (rx_bit != hist_q[len_m1]);
        win_nx.win = eval.take ? {hist_q[PAT_MAX-2:0], rx_bit} : hist_q;
        fill_nx = (eval.take && fill_q != FILL_W'(PAT_MAX)) ? fill_q + 1'b1 : fill_q;
        win_nx.full = fill_nx > {1'b0, len_m1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            hist_q <= win_nx.win;
            fill_q <= fill_nx;
        end
    end

    // R6
    skip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && skip) |=> $stable(hist_q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(hist_q) && $stable(fill_q)));

endmodule

// File: rtl/lcd_interval.sv
module lcd_interval #(
    parameter int INTV_BITS = 74112,
    parameter int ERR_LIMIT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic miss,
    input  logic code_ok,
    output logic loop_det,
    output logic period_end
);

    localparam int CNT_W   = $clog2(INTV_BITS);
    localparam int ERR_CAP = ERR_LIMIT + 1;
    localparam int ERR_W   = $clog2(ERR_CAP + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_nx;
    logic             det_q;

    assign period_end = bit_en && (cnt_q == CNT_W'(INTV_BITS - 1));
    assign err_nx     = (miss && err_q != ERR_W'(ERR_CAP)) ? err_q + 1'b1 : err_q;
    assign loop_det   = det_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err_q <= '0;
            det_q <= 1'b0;
        end else if (period_end) begin
            cnt_q <= '0;
            err_q <= '0;
            det_q <= (err_nx <= ERR_W'(ERR_LIMIT)) && code_ok;
        end else begin
            if (bit_en) cnt_q <= cnt_q + 1'b1;
            err_q <= err_nx;
        end
    end

    // R10
    err_sat_chk: assert property (@(posedge clk) disable iff (rst)
        err_q <= ERR_W'(ERR_CAP));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(INTV_BITS - 1));

    // R5
    det_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(det_q));

    // R3
    over_budget_chk: assert property (@(posedge clk) disable iff (rst)
        (period_end && err_q == ERR_W'(ERR_CAP)) |=> !det_q);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !det_q);

endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector
    import lcd_pkg::*;
#(
    parameter int INTV_BITS = 74112,
    parameter int ERR_LIMIT = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       bit_en,
    input  logic       fbit_mark,
    input  logic       framed_sel,
    input  logic [7:0] code_pat,
    input  logic [2:0] code_len_m1,
    output logic       loop_det
);

    pat_t             hist_q;
    window_t          win_nx;
    bit_eval_t        eval;
    logic [PAT_MAX-1:0] rot_hit;
    logic             code_ok;
    logic             period_end;
    logic             skip;

    assign skip = framed_sel & fbit_mark;

    lcd_history u_hist (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .rx_bit (rx_bit),
        .skip   (skip),
        .len_m1 (code_len_m1),
        .hist_q (hist_q),
        .win_nx (win_nx),
        .eval   (eval)
    );

    // One comparator per candidate rotation of the code
    for (genvar r = 0; r < PAT_MAX; r++) begin : g_rot
        assign rot_hit[r] = (LEN_W'(r) <= code_len_m1) &&
                            rot_fits(win_nx.win, code_pat, code_len_m1, r);
    end

    assign code_ok = win_nx.full && (|rot_hit);

    lcd_interval #(
        .INTV_BITS (INTV_BITS),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_intv (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .miss       (eval.miss),
        .code_ok    (code_ok),
        .loop_det   (loop_det),
        .period_end (period_end)
    );

    // R8
    code_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (period_end && !code_ok) |=> !loop_det);

    // R7
    unframed_take_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !framed_sel) |-> eval.take);

endmodule

// File: tb/loop_code_detector_bench.sv
module loop_code_detector_bench;

    localparam int INTV = 120;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_bit;
    logic       bit_en;
    logic       fbit_mark;
    logic       framed_sel;
    logic [7:0] code_pat;
    logic [2:0] code_len_m1;
    logic       loop_det;

    int   checks = 0;
    int   errors = 0;
    logic cur_flag = 1'b0;
    int   pos = 0;
    int   k = 0;
    logic [7:0] line_h = '0;
    logic [7:0] pat_r = 8'h01;
    int   len_r = 5;

    always #4 clk = ~clk;

    loop_code_detector #(.INTV_BITS(INTV), .ERR_LIMIT(15)) u_loop_code_detector (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_en(bit_en),
        .fbit_mark(fbit_mark), .framed_sel(framed_sel),
        .code_pat(code_pat), .code_len_m1(code_len_m1), .loop_det(loop_det)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: loop_det actual %b expected %b (pos %0d)", req, act, exp, pos);
        end
    endtask

    function automatic logic next_data();
        logic b;
        b = pat_r[len_r - 1 - (k % len_r)];
        k++;
        return b;
    endfunction

    // Drive one strobed bit at the current negedge, check after the edge
    task automatic send_bit(input logic b, input logic f, input logic exp_end, input string req);
        rx_bit = b; fbit_mark = f; bit_en = 1'b1;
        line_h = {line_h[6:0], b};
        @(negedge clk);
        if (pos == INTV - 1) begin
            chk(loop_det, exp_end, req);
            cur_flag = exp_end;
            pos = 0;
        end else begin
            chk(loop_det, cur_flag, "R5");
            pos++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b0; rx_bit = ~rx_bit; fbit_mark = 1'b1;
            @(negedge clk);
            chk(loop_det, cur_flag, "R11");
        end
    endtask

    task automatic pat_interval(input logic [INTV-1:0] flips, input logic exp, input string req);
        for (int p = 0; p < INTV; p++) send_bit(next_data() ^ flips[p], 1'b0, exp, req);
    endtask

    task automatic t_reset();
        rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b0; fbit_mark = 1'b0; framed_sel = 1'b0;
        code_pat = 8'h01; code_len_m1 = 3'd4;
        repeat (3) @(negedge clk);
        chk(loop_det, 1'b0, "R1");
        rst = 1'b0;
    endtask

    task automatic t_clean();
        pat_interval('0, 1'b1, "R2");
    endtask

    task automatic t_budget();
        logic [INTV-1:0] fl;
        fl = '0;
        for (int p = 10; p <= 70; p += 10) fl[p] = 1'b1;
        fl[INTV-1] = 1'b1;
        pat_interval(fl, 1'b0, "R8");       // 15 errors, but broken final window
        fl = '0;
        for (int p = 20; p <= 80; p += 10) fl[p] = 1'b1;
        pat_interval(fl, 1'b1, "R4");       // 1 carried + 14 = 15 errors
        fl = '0;
        for (int p = 0; p <= 70; p += 10) fl[p] = 1'b1;
        pat_interval(fl, 1'b0, "R3");       // 16 errors
        fl = '0;
        for (int p = 0; p <= 105; p += 7) fl[p] = 1'b1;
        pat_interval(fl, 1'b0, "R10");      // 32 errors
    endtask

    task automatic t_wrong_code();
        pat_interval('0, 1'b1, "R2");
        for (int p = 0; p < INTV; p++) send_bit(1'b1, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_idle();
        for (int p = 0; p < INTV; p++) begin
            if (p == 60) idle(7);
            send_bit(next_data(), 1'b0, 1'b1, "R11");
        end
    endtask

    task automatic fbit_interval(input logic framed, input logic exp, input string req);
        framed_sel = framed;
        for (int p = 0; p < INTV; p++) begin
            if (p % 8 == 7) send_bit(~line_h[4], 1'b1, exp, req);
            else            send_bit(next_data(), 1'b0, exp, req);
        end
    endtask

    task automatic t_framing();
        fbit_interval(1'b0, 1'b0, "R7");
        fbit_interval(1'b1, 1'b1, "R6");
        framed_sel = 1'b0;
    endtask

    task automatic t_length();
        code_pat = 8'h01; code_len_m1 = 3'd2;     // program 001, keep sending 00001
        pat_interval('0, 1'b0, "R9");
        pat_r = 8'h01; len_r = 3; k = 0;
        pat_interval('0, 1'b1, "R9");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_clean();
        t_budget();
        t_wrong_code();
        t_idle();
        t_framing();
        t_length();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule